// File: doc/BRIEF.md
# Dual-channel disk interface register decoder

This block is the host-side glue of an expansion card with two ATA-style disk channels. It accepts byte-wide accesses to a 4 KB I/O window and sorts each access into a task-file register, an alternate-status/control register, an interrupt port, an interrupt status port, a card identification bit or the card configuration latch. Task-file and alternate-status accesses become a registered chip select, a register index and a read or write strobe toward the addressed channel. Read data returns on the host side two clock edges after the access.

Each channel has an interrupt enable. Any write to the channel's interrupt port sets it, and a read of the same port clears it. The drive's interrupt request is masked by this enable, and the OR of both masked requests drives the single card interrupt. A configuration write selects which channel owns the one shared DMA request/acknowledge pair, and it also sets a fast-address-space flag for the card's bus wrapper.

Top module: `dchan_disk_glue`

## Requirements
- R1: After reset both interrupt enables are clear, `dma_route` and `fast_space` are 0, `card_irq` is 0, and all drive strobes and chip selects are 0. Interrupt requests from the drives therefore do not reach `card_irq` until enabled.
- R2: An access at 0x800 + 16*n (channel 1) or 0xC00 + 16*n (channel 2), n = 0..7, asserts `dev_tf_cs` bit 0 (channel 1) or bit 1 (channel 2), drives `dev_reg` = n, and pulses `dev_rd` or `dev_wr` for one cycle after the accepted access. A write forwards its data on `dev_wdata`. A read returns that channel's drive data on `host_rdata` with `host_rvalid` high one cycle after the strobe.
- R3: An access at 0x8E0 or 0xCE0 asserts `dev_alt_cs` bit 0 or bit 1, with `dev_reg` = 0 and the same strobe and read-data timing as R2.
- R4: A write of any value to 0x880 (channel 1) or 0xC80 (channel 2) sets only that channel's interrupt enable.
- R5: A read of 0x880 or 0xC80 returns 0x00 and clears only that channel's interrupt enable.
- R6: A read of 0x8A4 or 0xCA4 returns that channel's pending interrupt in bit 0, with bits 7..1 zero. The pending value is the drive request ANDed with the enable, registered once.
- R7: `card_irq` is the OR of both channels' pending values. It is registered once from the drive requests and enables, so it follows a change one edge later.
- R8: Reads of 0x8A0..0x8A3 return in bit 0 one bit of the card code 4'b0011 (0x8A0 gives bit 0), with bits 7..1 zero.
- R9: A write to offset 0x000 latches data bit 0 into `dma_route` (0 = channel 1, 1 = channel 2) and data bit 5 into `fast_space`.
- R10: `dma_req` is the DMA request of the channel chosen by `dma_route`. `dev_dmack` carries `dma_ack` on that channel's bit only. Both outputs are registered once.
- R11: Any other offset is unmapped. This includes 0x000 on a read, non-16-byte-aligned task-file offsets, 0xCA0..0xCA3 and writes to status or ID ports. A read of an unmapped offset returns 0xFF. No unmapped access produces a drive strobe or changes an enable or the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Offset within the I/O window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid |
| dev_tf_cs | output | 2 | Task-file chip select per channel |
| dev_alt_cs | output | 2 | Alternate-status/control select per channel |
| dev_reg | output | 3 | Task-file register index |
| dev_rd | output | 1 | Drive read strobe |
| dev_wr | output | 1 | Drive write strobe |
| dev_wdata | output | 8 | Write data toward the drives |
| dev0_rdata | input | 8 | Read data from channel 1 |
| dev1_rdata | input | 8 | Read data from channel 2 |
| dev_irq | input | 2 | Drive interrupt requests, bit 0 = channel 1 |
| card_irq | output | 1 | Combined card interrupt |
| dev_dmarq | input | 2 | Drive DMA requests |
| dma_ack | input | 1 | DMA acknowledge from the shared engine |
| dma_req | output | 1 | Routed DMA request to the shared engine |
| dev_dmack | output | 2 | Routed DMA acknowledge per channel |
| dma_route | output | 1 | Latched DMA channel select |
| fast_space | output | 1 | Latched fast-address-space flag |

## Verification
A read of an interrupt port clears that channel's enable in the same cycle that the drive's interrupt request may rise. The request and the read strobe are therefore driven on the same clock. Because the pending value is computed from the enable held before the edge, `card_irq` must show exactly one high cycle and then drop. A status read issued afterwards must report 0. The bench checks the mid-access and post-access values of `card_irq` on every access, including random ones where interrupt-port traffic and request changes coincide. In the same way, a configuration write can land together with a DMA request change, and the routed request is judged against the newly latched channel.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  localparam int TF_IDX_W = 3;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_TF   = 3'd1,
    RG_ALT  = 3'd2,
    RG_IRQ  = 3'd3,
    RG_STAT = 3'd4,
    RG_ID   = 3'd5,
    RG_CFG  = 3'd6
  } region_e;

  typedef struct packed {
    region_e               region;
    logic                  chan;
    logic [TF_IDX_W-1:0]   idx;
  } dec_t;

endpackage

// File: rtl/dcd_addr_decode.sv
module dcd_addr_decode
  import dcd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int SPAN_W   = 10,
  parameter int STEP_W   = 4,
  parameter int CH0_PAGE = 2,
  parameter int CH1_PAGE = 3,
  parameter int IRQ_OFS  = 'h080,
  parameter int ID_OFS   = 'h0A0,
  parameter int ID_LEN   = 4,
  parameter int STAT_OFS = 'h0A4,
  parameter int ALT_OFS  = 'h0E0
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam int PAGE_W  = ADDR_W - SPAN_W;
  localparam int TF_SPAN = (1 << TF_IDX_W) << STEP_W;

  logic [PAGE_W-1:0] page;
  logic [SPAN_W-1:0] lo;
  logic              in_ch;

  always_comb begin
    page  = addr[ADDR_W-1:SPAN_W];
    lo    = addr[SPAN_W-1:0];
    in_ch = (page == PAGE_W'(CH0_PAGE)) || (page == PAGE_W'(CH1_PAGE));
    dec   = '{region: RG_NONE, chan: 1'b0, idx: '0};
    if (addr == '0) begin
      dec.region = RG_CFG;
    end else if (in_ch) begin
      dec.chan = (page == PAGE_W'(CH1_PAGE));
      if ((32'(lo) < TF_SPAN) && (lo[STEP_W-1:0] == '0)) begin
        dec.region = RG_TF;
        dec.idx    = lo[STEP_W +: TF_IDX_W];
      end else if (lo == SPAN_W'(ALT_OFS)) begin
        dec.region = RG_ALT;
      end else if (lo == SPAN_W'(IRQ_OFS)) begin
        dec.region = RG_IRQ;
      end else if (lo == SPAN_W'(STAT_OFS)) begin
        dec.region = RG_STAT;
      end else if (!dec.chan && (32'(lo) >= ID_OFS) && (32'(lo) < ID_OFS + ID_LEN)) begin
        dec.region = RG_ID;
        dec.idx    = TF_IDX_W'(32'(lo) - ID_OFS);
      end
    end
  end

endmodule

// File: rtl/dcd_irq_chan.sv
module dcd_irq_chan (
  input  logic clk,
  input  logic rst,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic drv_irq,
  output logic en_q,
  output logic pend_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (set_stb)      en_q <= 1'b1;
      else if (clr_stb) en_q <= 1'b0;
      pend_q <= drv_irq & en_q;
    end
  end

  assert_enable_set_R4: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> en_q);

  assert_enable_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !set_stb) |=> !en_q);

  assert_masked_R6: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !pend_q);

  assert_enable_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!set_stb && !clr_stb) |=> $stable(en_q));

endmodule

// File: rtl/dcd_cfg_dma.sv
module dcd_cfg_dma #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic           wr_route,
  input  logic           wr_fast,
  input  logic [NCH-1:0] dev_dmarq,
  input  logic           dma_ack,
  output logic           route_q,
  output logic           fast_q,
  output logic           dma_req,
  output logic [NCH-1:0] dev_dmack
);

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q   <= 1'b0;
      fast_q    <= 1'b0;
      dma_req   <= 1'b0;
      dev_dmack <= '0;
    end else begin
      if (cfg_wr) begin
        route_q <= wr_route;
        fast_q  <= wr_fast;
      end
      dma_req <= dev_dmarq[route_q];
      for (int c = 0; c < NCH; c++) begin
        dev_dmack[c] <= dma_ack && (route_q == 1'(c));
      end
    end
  end

  assert_cfg_latch_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (route_q == $past(wr_route)) && (fast_q == $past(wr_fast)));

  assert_dmack_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_dmack));

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(route_q) && $stable(fast_q));

endmodule

// File: rtl/dchan_disk_glue.sv
module dchan_disk_glue
  import dcd_pkg::*;
#(
  parameter int       ADDR_W    = 12,
  parameter int       DW        = 8,
  parameter int       ROUTE_BIT = 0,
  parameter int       FAST_BIT  = 5,
  parameter int       ID_LEN    = 4,
  parameter logic [3:0] CARD_ID = 4'b0011
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_sel,
  input  logic                host_wr,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DW-1:0]       host_wdata,
  output logic [DW-1:0]       host_rdata,
  output logic                host_rvalid,
  output logic [1:0]          dev_tf_cs,
  output logic [1:0]          dev_alt_cs,
  output logic [TF_IDX_W-1:0] dev_reg,
  output logic                dev_rd,
  output logic                dev_wr,
  output logic [DW-1:0]       dev_wdata,
  input  logic [DW-1:0]       dev0_rdata,
  input  logic [DW-1:0]       dev1_rdata,
  input  logic [1:0]          dev_irq,
  output logic                card_irq,
  input  logic [1:0]          dev_dmarq,
  input  logic                dma_ack,
  output logic                dma_req,
  output logic [1:0]          dev_dmack,
  output logic                dma_route,
  output logic                fast_space
);

  localparam int NCH  = 2;
  localparam int ID_W = $clog2(ID_LEN);

  dec_t           dec;
  logic [NCH-1:0] set_stb, clr_stb, irq_en, irq_pend;
  logic           drv_hit, cfg_wr;
  logic [DW-1:0]  drv_rd [NCH];
  logic [DW-1:0]  rd_mux;

  logic           s1_valid, s1_wr, s1_chan;
  region_e        s1_region;
  logic [ID_W-1:0] s1_idbit;

  dcd_addr_decode #(.ADDR_W(ADDR_W), .ID_LEN(ID_LEN)) u_dec (
    .addr (host_addr),
    .dec  (dec)
  );

  assign drv_hit   = host_sel && ((dec.region == RG_TF) || (dec.region == RG_ALT));
  assign cfg_wr    = host_sel && host_wr && (dec.region == RG_CFG);
  assign drv_rd[0] = dev0_rdata;
  assign drv_rd[1] = dev1_rdata;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign set_stb[c] = host_sel &&  host_wr && (dec.region == RG_IRQ) && (dec.chan == 1'(c));
    assign clr_stb[c] = host_sel && !host_wr && (dec.region == RG_IRQ) && (dec.chan == 1'(c));

    dcd_irq_chan u_irq (
      .clk     (clk),
      .rst     (rst),
      .set_stb (set_stb[c]),
      .clr_stb (clr_stb[c]),
      .drv_irq (dev_irq[c]),
      .en_q    (irq_en[c]),
      .pend_q  (irq_pend[c])
    );
  end

  dcd_cfg_dma #(.NCH(NCH)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .wr_route  (host_wdata[ROUTE_BIT]),
    .wr_fast   (host_wdata[FAST_BIT]),
    .dev_dmarq (dev_dmarq),
    .dma_ack   (dma_ack),
    .route_q   (dma_route),
    .fast_q    (fast_space),
    .dma_req   (dma_req),
    .dev_dmack (dev_dmack)
  );

  // stage 1: drive-side strobes and captured decode
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_wr      <= 1'b0;
      s1_chan    <= 1'b0;
      s1_region  <= RG_NONE;
      s1_idbit   <= '0;
      dev_tf_cs  <= '0;
      dev_alt_cs <= '0;
      dev_reg    <= '0;
      dev_rd     <= 1'b0;
      dev_wr     <= 1'b0;
      dev_wdata  <= '0;
    end else begin
      s1_valid  <= host_sel;
      s1_wr     <= host_wr;
      s1_chan   <= dec.chan;
      s1_region <= dec.region;
      s1_idbit  <= dec.idx[ID_W-1:0];
      for (int c = 0; c < NCH; c++) begin
        dev_tf_cs[c]  <= host_sel && (dec.region == RG_TF)  && (dec.chan == 1'(c));
        dev_alt_cs[c] <= host_sel && (dec.region == RG_ALT) && (dec.chan == 1'(c));
      end
      dev_reg <= (host_sel && (dec.region == RG_TF)) ? dec.idx : '0;
      dev_rd  <= drv_hit && !host_wr;
      dev_wr  <= drv_hit &&  host_wr;
      if (host_sel && host_wr) dev_wdata <= host_wdata;
    end
  end

  always_comb begin
    case (s1_region)
      RG_TF, RG_ALT: rd_mux = drv_rd[s1_chan];
      RG_IRQ:        rd_mux = '0;
      RG_STAT:       rd_mux = {{(DW-1){1'b0}}, irq_pend[s1_chan]};
      RG_ID:         rd_mux = {{(DW-1){1'b0}}, CARD_ID[s1_idbit]};
      default:       rd_mux = '1;
    endcase
  end

  // stage 2: host read return and card interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      card_irq    <= 1'b0;
    end else begin
      host_rvalid <= s1_valid && !s1_wr;
      host_rdata  <= rd_mux;
      card_irq    <= |(dev_irq & irq_en);
    end
  end

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dev_tf_cs, dev_alt_cs}));

  assert_strobe_has_cs_R3: assert property (@(posedge clk) disable iff (rst)
    (dev_rd || dev_wr) |-> (|{dev_tf_cs, dev_alt_cs}));

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (host_sel && !host_wr) |=> ##1 host_rvalid);

  assert_card_or_R7: assert property (@(posedge clk) disable iff (rst)
    card_irq == (|irq_pend));

  assert_unmapped_ff_R11: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_wr && (s1_region == RG_NONE)) |=> (host_rdata == '1));

endmodule

// File: tb/dchan_disk_glue_bench.sv
module dchan_disk_glue_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [1:0]  dev_tf_cs, dev_alt_cs;
  logic [2:0]  dev_reg;
  logic        dev_rd, dev_wr;
  logic [7:0]  dev_wdata, dev0_rdata, dev1_rdata;
  logic [1:0]  dev_irq = '0;
  logic        card_irq;
  logic [1:0]  dev_dmarq = '0;
  logic        dma_ack = 1'b0;
  logic        dma_req;
  logic [1:0]  dev_dmack;
  logic        dma_route, fast_space;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] m_en = '0;
  logic       m_route = 1'b0;
  logic       m_fast = 1'b0;
  localparam logic [3:0] EXP_ID = 4'b0011;

  always #5 clk = ~clk;

  // simple drive models: data identifies channel and register index
  assign dev0_rdata = {5'b10100, dev_reg};
  assign dev1_rdata = {5'b11000, dev_reg};

  dchan_disk_glue u_dchan_disk_glue (
    .clk, .rst, .host_sel, .host_wr, .host_addr, .host_wdata,
    .host_rdata, .host_rvalid, .dev_tf_cs, .dev_alt_cs, .dev_reg,
    .dev_rd, .dev_wr, .dev_wdata, .dev0_rdata, .dev1_rdata, .dev_irq,
    .card_irq, .dev_dmarq, .dma_ack, .dma_req, .dev_dmack,
    .dma_route, .fast_space
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // region codes: 0 none, 1 task file, 2 alt, 3 irq port, 4 status, 5 id, 6 config
  function automatic void exp_dec(input logic [11:0] a, input logic wr,
                                  output int rg, output int ch, output int idx);
    rg = 0; ch = 0; idx = 0;
    if (a == 12'h000) rg = 6;
    for (int c = 0; c < 2; c++) begin
      int base;
      base = (c == 0) ? 'h800 : 'hC00;
      for (int n = 0; n < 8; n++)
        if (int'(a) == base + 16 * n) begin rg = 1; ch = c; idx = n; end
      if (int'(a) == base + 'hE0) begin rg = 2; ch = c; end
      if (int'(a) == base + 'h80) begin rg = 3; ch = c; end
      if (int'(a) == base + 'hA4) begin rg = 4; ch = c; end
    end
    for (int n = 0; n < 4; n++)
      if (int'(a) == 'h8A0 + n) begin rg = 5; idx = n; end
    if (rg == 6 && !wr) rg = 0;
  endfunction

  function automatic logic [7:0] exp_rd(input int rg, input int ch, input int idx,
                                        input logic [1:0] irq, input logic [1:0] en);
    case (rg)
      1:       exp_rd = (ch == 1) ? {5'b11000, 3'(idx)} : {5'b10100, 3'(idx)};
      2:       exp_rd = (ch == 1) ? 8'hC0 : 8'hA0;
      3:       exp_rd = 8'h00;
      4:       exp_rd = {7'b0, irq[ch] & en[ch]};
      5:       exp_rd = {7'b0, EXP_ID[idx]};
      default: exp_rd = 8'hFF;
    endcase
  endfunction

  function automatic string tag_of(input int rg);
    case (rg)
      1: tag_of = "R2 task-file read";
      2: tag_of = "R3 alt read";
      3: tag_of = "R5 irq port read";
      4: tag_of = "R6 status read";
      5: tag_of = "R8 id read";
      default: tag_of = "R11 unmapped read";
    endcase
  endfunction

  // one host access; irq, dma request and ack change together with the access
  task automatic access(input logic wr, input logic [11:0] a, input logic [7:0] wd,
                        input logic [1:0] irq_v, input logic [1:0] rq_v, input logic ack_v);
    int rg, ch, idx;
    logic [1:0] en_old;
    exp_dec(a, wr, rg, ch, idx);
    en_old = m_en;
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = wd;
    dev_irq = irq_v; dev_dmarq = rq_v; dma_ack = ack_v;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
    if (rg == 3) m_en[ch] = wr;
    if (rg == 6 && wr) begin m_route = wd[0]; m_fast = wd[5]; end
    chk("R2 task-file select", dev_tf_cs, (rg == 1) ? (2'b01 << ch) : 2'b00);
    chk("R3 alt select", dev_alt_cs, (rg == 2) ? (2'b01 << ch) : 2'b00);
    chk("R2 register index", dev_reg, (rg == 1) ? idx : 0);
    chk("R11 drive strobes", {dev_rd, dev_wr},
        (rg == 1 || rg == 2) ? (wr ? 2'b01 : 2'b10) : 2'b00);
    if (wr && (rg == 1 || rg == 2)) chk("R2 write data", dev_wdata, wd);
    chk("R7 card irq mid", card_irq, |(irq_v & en_old));
    chk("R9 route latch", dma_route, m_route);
    chk("R9 fast latch", fast_space, m_fast);
    @(negedge clk);
    chk("R2 read valid", host_rvalid, !wr);
    if (!wr) chk(tag_of(rg), host_rdata, exp_rd(rg, ch, idx, irq_v, en_old));
    chk("R7 card irq after", card_irq, |(irq_v & m_en));
    chk("R10 routed request", dma_req, rq_v[m_route]);
    chk("R10 routed ack", dev_dmack, ack_v ? (2'b01 << m_route) : 2'b00);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500us;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 card irq", card_irq, 0);
    chk("R1 route", dma_route, 0);
    chk("R1 fast", fast_space, 0);
    chk("R1 selects", {dev_tf_cs, dev_alt_cs, dev_rd, dev_wr}, 0);
    chk("R1 rvalid", host_rvalid, 0);
    dev_irq = 2'b11;
    repeat (2) @(negedge clk);
    chk("R1 irq masked after reset", card_irq, 0);
    access(1'b0, 12'h8A4, 8'h00, 2'b11, 2'b00, 1'b0);

    // R2: every task-file step on both channels, reads then writes
    for (int c = 0; c < 2; c++)
      for (int n = 0; n < 8; n++) begin
        access(1'b0, 12'(((c == 0) ? 'h800 : 'hC00) + 16 * n), 8'h00, 2'b00, 2'b00, 1'b0);
        access(1'b1, 12'(((c == 0) ? 'h800 : 'hC00) + 16 * n), 8'(8'h30 + n), 2'b00, 2'b00, 1'b0);
      end
    // R3: alternate status/control
    access(1'b0, 12'h8E0, 8'h00, 2'b00, 2'b00, 1'b0);
    access(1'b1, 12'hCE0, 8'h06, 2'b00, 2'b00, 1'b0);

    // R4/R5/R6/R7: per-channel enable and status
    access(1'b1, 12'hC80, 8'h5A, 2'b11, 2'b00, 1'b0);
    access(1'b0, 12'h8A4, 8'h00, 2'b11, 2'b00, 1'b0);
    access(1'b0, 12'hCA4, 8'h00, 2'b11, 2'b00, 1'b0);
    access(1'b1, 12'h880, 8'h00, 2'b01, 2'b00, 1'b0);
    access(1'b0, 12'hC80, 8'h00, 2'b11, 2'b00, 1'b0);
    access(1'b0, 12'h8A4, 8'h00, 2'b11, 2'b00, 1'b0);
    // R11: status and id writes, misaligned and hole offsets leave enables
    access(1'b1, 12'h8A4, 8'hFF, 2'b01, 2'b00, 1'b0);
    access(1'b0, 12'h804, 8'h00, 2'b01, 2'b00, 1'b0);
    access(1'b0, 12'hCA0, 8'h00, 2'b01, 2'b00, 1'b0);
    access(1'b0, 12'h000, 8'h00, 2'b01, 2'b00, 1'b0);
    access(1'b0, 12'h123, 8'h00, 2'b01, 2'b00, 1'b0);
    access(1'b1, 12'h8A1, 8'h00, 2'b01, 2'b00, 1'b0);
    // R5 with R7: irq port read coincides with a rising request (one-cycle pulse)
    access(1'b0, 12'h880, 8'h00, 2'b00, 2'b00, 1'b0);
    access(1'b1, 12'h880, 8'h00, 2'b00, 2'b00, 1'b0);
    access(1'b0, 12'h880, 8'h00, 2'b01, 2'b00, 1'b0);
    access(1'b0, 12'h8A4, 8'h00, 2'b01, 2'b00, 1'b0);

    // R8: card identification bits
    for (int n = 0; n < 4; n++) access(1'b0, 12'(12'h8A0 + n), 8'h00, 2'b00, 2'b00, 1'b0);

    // R9/R10: configuration and DMA routing, including a request change on the write
    access(1'b1, 12'h000, 8'h21, 2'b10, 2'b10, 1'b1);
    access(1'b1, 12'hFFF, 8'h00, 2'b01, 2'b01, 1'b1);
    access(1'b1, 12'h000, 8'h00, 2'b01, 2'b01, 1'b1);
    access(1'b1, 12'h000, 8'hDE, 2'b00, 2'b10, 1'b0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [31:0] r;
      r = $urandom;
      case (r[2:0])
        3'd0:    a = 12'($urandom);
        3'd1:    a = {2'b1, r[3], 5'b0, r[6:4], 1'b0} << 0;
        3'd2:    a = r[3] ? 12'hC80 : 12'h880;
        3'd3:    a = r[3] ? 12'hCA4 : 12'h8A4;
        3'd4:    a = 12'(12'h8A0 + r[5:4]);
        3'd5:    a = r[3] ? 12'hCE0 : 12'h8E0;
        3'd6:    a = 12'h000;
        default: a = {1'b1, r[3], 3'b0, r[6:4], 4'b0};
      endcase
      access(r[8], a, 8'($urandom), r[10:9], r[12:11], r[13]);
    end
    summary();
  end

endmodule